// File: doc/BRIEF.md
# Level-Held Limit Timer with PWM Time Base

This block is an up-counting timer that serves as the time base of one PWM output. The counter runs from 0 up to a programmable period value. It wraps to 0 on the clock after it reaches that value, and it raises a one-cycle period-match strobe at that point. The PWM level is high while the count is below a programmable duty value and low from the duty value onward. Duty 0 therefore gives a flat low output, and a duty above the period gives a flat high output.

An external reset input can hold the counter at zero for as long as that input stays at its active level. A mode field selects the active level: low, high, or none. The external input passes through a synchroniser before it is used, so entering and leaving the hold each take effect two clocks late. While the counter is held, the PWM output keeps the level it had in the last counting cycle. A pulse that is high when the hold begins therefore stays high through the whole hold. It continues after release until the count reaches the duty value.

When the enable input is low, the counter keeps its value, the PWM output is low, no strobe is raised and the external input has no effect. The asynchronous active-low reset `rst_n` is expected to be released synchronously to `clk`.

Top module: `lvl_limit_timer`

## Requirements
- R1: While `rst_n` is low and after it is released, `count` is 0, `pwm` is 0 and `period_hit` is 0 until the timer is enabled.
- R2: When enabled and not held, `count` rises by exactly 1 on each clock edge. Below the period it never jumps or skips.
- R3: When enabled and not held, `period_hit` is high in exactly the cycles where `count` equals `period`, and `count` is 0 after the following edge. With `period` = 255, the count covers all 256 values.
- R4: Mode `5'b00110` holds the count at 0 while `ext_rst` is low. Mode `5'b00111` holds it while `ext_rst` is high. Any other mode value ignores `ext_rst`, and the timer runs free.
- R5: Take the first rising edge that samples `ext_rst` at a new level. The hold begins or ends on the third edge counted from that one. Entering: the count is still non-zero after the second edge and is 0 after the third. Leaving: the count is still 0 after the second edge and is 1 after the third.
- R6: With `en` low, `count` keeps its value whatever `ext_rst` does, and `pwm` and `period_hit` are both 0.
- R7: In counting cycles, `pwm` is 1 exactly when `count` < `duty`. Duty 0 gives a constant low. A duty above the period gives a constant high.
- R8: While the count is held, `pwm` keeps the level it had in the last counting cycle before the hold. When the count restarts from 0 after release, `pwm` is high if `duty` is non-zero.
- R9: `period_hit` is never high while the count is held, even when `count` equals `period`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Timer enable |
| mode | input | 5 | Hold polarity select: 00110 holds on a low level, 00111 holds on a high level, any other value means no hold |
| ext_rst | input | 1 | External level reset, asynchronous to `clk` |
| period | input | CNT_W | Count value at which the timer wraps |
| duty | input | CNT_W | Count value at which the PWM output goes low |
| count | output | CNT_W | Current count |
| period_hit | output | 1 | One-cycle strobe when the count reaches the period |
| pwm | output | 1 | PWM level |

## Verification
The bench builds the timer with the default parameters: an 8-bit count and a two-stage synchroniser. The 8-bit width makes a full 256-value wrap at period 255 reachable in a few hundred cycles, and it also makes every duty corner case reachable: duty 0, duty above the period, and duty above the count when a hold begins. The two-stage setting makes the hold latency an exact three-edge window, so the bench can check it cycle by cycle both on entering and on leaving a hold, in both polarities.

// File: rtl/lrt_pkg.sv
package lrt_pkg;

  localparam int MODE_W = 5;

  localparam logic [MODE_W-1:0] MODE_HOLD_LOW  = 5'b00110;
  localparam logic [MODE_W-1:0] MODE_HOLD_HIGH = 5'b00111;

  typedef enum logic [1:0] {
    POL_NONE = 2'd0,
    POL_LOW  = 2'd1,
    POL_HIGH = 2'd2
  } hold_pol_e;

  function automatic hold_pol_e decode_pol(logic [MODE_W-1:0] m);
    hold_pol_e p;
    case (m)
      MODE_HOLD_LOW:  p = POL_LOW;
      MODE_HOLD_HIGH: p = POL_HIGH;
      default:        p = POL_NONE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/lrt_sync.sv
module lrt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d = din;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/lrt_hold_dec.sv
module lrt_hold_dec
  import lrt_pkg::*;
(
  input  logic              en,
  input  logic [MODE_W-1:0] mode,
  input  logic              ext_sync,
  output logic              hold
);

  hold_pol_e pol;

  always_comb begin
    pol  = decode_pol(mode);
    hold = 1'b0;
    if (en) begin
      case (pol)
        POL_LOW:  hold = ~ext_sync;
        POL_HIGH: hold = ext_sync;
        default:  hold = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/lrt_counter.sv
module lrt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hold,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;
  logic             at_limit;

  always_comb begin
    at_limit = (cnt_q == period);
    cnt_ce   = en;
    wrap     = en & ~hold & at_limit;
    if (hold || at_limit) cnt_d = '0;
    else                  cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/lrt_pwm.sv
module lrt_pwm #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hold,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm
);

  logic below;
  logic held_q;
  logic held_d;

  always_comb begin
    below = (count < duty);
    if (!en)       held_d = 1'b0;
    else if (hold) held_d = held_q;
    else           held_d = below;
    pwm = en & (hold ? held_q : below);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

endmodule

// File: rtl/lvl_limit_timer.sv
module lvl_limit_timer
  import lrt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [MODE_W-1:0] mode,
  input  logic              ext_rst,
  input  logic [CNT_W-1:0]  period,
  input  logic [CNT_W-1:0]  duty,
  output logic [CNT_W-1:0]  count,
  output logic              period_hit,
  output logic              pwm
);

  logic ext_sync;
  logic hold;

  lrt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ext_rst),
    .dout (ext_sync)
  );

  lrt_hold_dec u_dec (
    .en      (en),
    .mode    (mode),
    .ext_sync(ext_sync),
    .hold    (hold)
  );

  lrt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .hold  (hold),
    .period(period),
    .count (count),
    .wrap  (period_hit)
  );

  lrt_pwm #(.CNT_W(CNT_W)) u_pwm (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .hold (hold),
    .count(count),
    .duty (duty),
    .pwm  (pwm)
  );

endmodule

// File: rtl/lvl_limit_timer_chk.sv
module lvl_limit_timer_chk
  import lrt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [MODE_W-1:0] mode,
  input logic              ext_rst,
  input logic [CNT_W-1:0]  count,
  input logic              period_hit,
  input logic              pwm
);

  logic [1:0] started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              started <= 2'd0;
    else if (started != 2'd3) started <= started + 2'd1;
  end

  // R6: disabled timer keeps its count
  p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (started != 2'd0 && !en) |=> $stable(count));

  // R6: disabled timer drives nothing
  p_quiet_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!pwm && !period_hit));

  // R3: a strobe is followed by a zero count
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    period_hit |=> (count == '0));

  // R2: any non-zero count after an enabled cycle is the previous plus one
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (started != 2'd0 && $past(en) && count != '0) |-> (count == $past(count) + 1'b1));

  generate
    if (SYNC_STAGES == 2) begin : g_lat
      // R5: high-polarity hold clears the count three edges after sampling
      p_enter_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (started == 2'd3 && $past(en) && $past(mode) == MODE_HOLD_HIGH && $past(ext_rst, 3))
        |-> (count == '0));
    end
  endgenerate

endmodule

bind lvl_limit_timer lvl_limit_timer_chk #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .mode      (mode),
  .ext_rst   (ext_rst),
  .count     (count),
  .period_hit(period_hit),
  .pwm       (pwm)
);

// File: tb/lvl_limit_timer_test.sv
module lvl_limit_timer_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [4:0] mode;
  logic       ext_rst;
  logic [7:0] period;
  logic [7:0] duty;
  logic [7:0] count;
  logic       period_hit;
  logic       pwm;

  int    checks   = 0;
  int    failures = 0;
  int    cycles   = 0;
  string cur_req  = "R1";
  bit    cmp_on   = 1'b0;

  // reference model state
  int m_cnt;
  bit m_held;
  bit pipe[$];

  always #10 clk = ~clk;

  lvl_limit_timer uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .ext_rst(ext_rst),
    .period(period), .duty(duty), .count(count),
    .period_hit(period_hit), .pwm(pwm)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit m_hold();
    if (!en) return 1'b0;
    if (mode == 5'b00110) return (pipe[0] == 1'b0);
    if (mode == 5'b00111) return (pipe[0] == 1'b1);
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt  = 0;
      m_held = 1'b0;
      pipe   = '{1'b0, 1'b0};
    end else begin
      bit h;
      h = m_hold();
      if (!en)     m_held = 1'b0;
      else if (!h) m_held = (m_cnt < int'(duty));
      if (en) begin
        if (h)                        m_cnt = 0;
        else if (m_cnt == int'(period)) m_cnt = 0;
        else                          m_cnt = (m_cnt + 1) % 256;
      end
      pipe.push_back(ext_rst);
      void'(pipe.pop_front());
    end
  end

  always @(negedge clk) begin
    #5;
    if (cmp_on && rst_n) begin
      bit h, e_pwm, e_hit;
      h     = m_hold();
      e_pwm = en && (h ? m_held : (m_cnt < int'(duty)));
      e_hit = en && !h && (m_cnt == int'(period));
      chk(int'(count) == m_cnt, cur_req, "count", int'(count), m_cnt);
      chk(pwm == e_pwm, cur_req, "pwm", int'(pwm), int'(e_pwm));
      chk(period_hit == e_hit, cur_req, "period_hit", int'(period_hit), int'(e_hit));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; en = 1'b0; mode = 5'b00111; ext_rst = 1'b0;
    period = 8'd9; duty = 8'd4;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #5;
    chk(count == 8'd0, "R1", "count in reset", int'(count), 0);
    chk(pwm == 1'b0, "R1", "pwm in reset", int'(pwm), 0);
    chk(period_hit == 1'b0, "R1", "period_hit in reset", int'(period_hit), 0);
    @(negedge clk); rst_n = 1'b1; cmp_on = 1'b1;
    repeat (3) @(negedge clk);
    #5 chk(count == 8'd0, "R1", "count idle after reset", int'(count), 0);

    // R2 / R3 free counting with wrap
    @(negedge clk); en = 1'b1; cur_req = "R2";
    repeat (25) @(negedge clk);
    cur_req = "R3";
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 20 && !seen; i++) begin
        @(negedge clk); #5;
        if (period_hit) seen = 1'b1;
      end
      chk(seen, "R3", "period_hit seen", int'(seen), 1);
      chk(count == period, "R3", "count at strobe", int'(count), int'(period));
      @(negedge clk); #5;
      chk(count == 8'd0, "R3", "count after strobe", int'(count), 0);
    end

    // R7 duty corners
    cur_req = "R7";
    @(negedge clk); duty = 8'd0;
    repeat (24) @(negedge clk);
    #5 chk(pwm == 1'b0, "R7", "pwm with duty 0", int'(pwm), 0);
    @(negedge clk); duty = 8'd12;
    repeat (24) @(negedge clk);
    #5 chk(pwm == 1'b1, "R7", "pwm with duty above period", int'(pwm), 1);

    // R5 / R8 enter hold with pwm high
    @(negedge clk); period = 8'd200; duty = 8'd150; cur_req = "R5";
    repeat (30) @(negedge clk);
    ext_rst = 1'b1;
    @(negedge clk); @(negedge clk); #5;
    chk(count != 8'd0, "R5", "count still running after two edges", int'(count), 1);
    @(negedge clk); #5;
    chk(count == 8'd0, "R5", "count cleared on third edge", int'(count), 0);
    cur_req = "R8";
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #5;
      chk(count == 8'd0, "R8", "count held", int'(count), 0);
      chk(pwm == 1'b1, "R8", "pwm stays high in hold", int'(pwm), 1);
    end
    @(negedge clk); ext_rst = 1'b0; cur_req = "R5";
    @(negedge clk); @(negedge clk); #5;
    chk(count == 8'd0, "R5", "count still held after two edges", int'(count), 0);
    @(negedge clk); #5;
    chk(count == 8'd1, "R5", "count restarts on third edge", int'(count), 1);
    chk(pwm == 1'b1, "R8", "pwm high after release", int'(pwm), 1);

    // R4 low polarity and no polarity
    cur_req = "R4";
    repeat (20) @(negedge clk);
    mode = 5'b00110;
    repeat (10) @(negedge clk);
    #5 chk(count == 8'd0, "R4", "low-level hold", int'(count), 0);
    @(negedge clk); ext_rst = 1'b1;
    repeat (10) @(negedge clk);
    #5 chk(count != 8'd0, "R4", "runs with input high", int'(count), 1);
    @(negedge clk); mode = 5'b00000;
    begin
      int c0;
      #5 c0 = int'(count);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); ext_rst = ~ext_rst;
      end
      #5 chk(int'(count) == c0 + 6, "R4", "other mode ignores input", int'(count), c0 + 6);
    end

    // R6 disabled
    cur_req = "R6";
    @(negedge clk); en = 1'b0; mode = 5'b00111;
    begin
      int c0;
      #5 c0 = int'(count);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); ext_rst = ~ext_rst;
      end
      #5;
      chk(int'(count) == c0, "R6", "count frozen", int'(count), c0);
      chk(pwm == 1'b0, "R6", "pwm low when off", int'(pwm), 0);
      chk(period_hit == 1'b0, "R6", "no strobe when off", int'(period_hit), 0);
    end

    // R9 no strobe while held even at period 0
    @(negedge clk); en = 1'b1; ext_rst = 1'b1; period = 8'd0; cur_req = "R9";
    repeat (4) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #5;
      chk(period_hit == 1'b0, "R9", "no strobe in hold", int'(period_hit), 0);
    end

    // R3 full-range wrap
    @(negedge clk); mode = 5'b00000; period = 8'd255; duty = 8'd128; cur_req = "R3";
    repeat (300) @(negedge clk);

    cmp_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule